// File: doc/BRIEF.md
# Two-Operand Integer ALU with Flags

This block executes one register/memory integer operation per accepted request. A caller presents a one-byte opcode, the operand-specifier byte that follows it, the value of the register operand and the value of the memory operand. The opcode picks both the operation and the direction. In one direction the register is combined into the memory operand and the result goes back to memory. In the other direction the memory operand is combined into a register and the result goes back to that register.

One clock after a request, the block presents the result, a write-back target code, the register index for register write-back and an illegal-operation indication. The sign, zero and overflow flags are held in registers and are updated only by the operations that define them. Operand fetch, address generation and the memory itself belong to the surrounding pipeline.

Top module: `alu2op_core`

## Requirements
- R1: Opcodes 0x01 (add), 0x29 (subtract), 0x21 (AND), 0x09 (OR) and 0x31 (XOR) combine the register operand into the memory operand. They return write-back target code 2'b10 (memory). The write-back code values are 2'b00 none, 2'b01 register and 2'b10 memory.
- R2: Opcodes 0x03, 0x2B, 0x23, 0x0B and 0x33 perform the same five operations with the memory operand combined into the register. They return target code 2'b01 and a register index equal to bits 5:3 of the operand-specifier byte.
- R3: Operand order for subtraction: 0x29 yields memory minus register, and 0x2B yields register minus memory.
- R4: Opcode 0x39 compares memory minus register, and 0x3B compares register minus memory. Both return target code 2'b00 and set the sign flag from bit 31 of the difference and the zero flag when the difference is zero.
- R5: After a subtract or compare, the overflow flag is 1 exactly when the 32-bit difference differs from the same difference taken one bit wider with sign extension (for example 0x80000000 minus 1 sets it).
- R6: Addition wraps at 32 bits. The overflow flag is set when both addends share a sign and the sum has the other sign (0x7FFFFFFF+1 gives 0x80000000 with overflow; 0xFFFFFFFF+1 gives 0 with zero flag and no overflow).
- R7: AND, OR and XOR clear the overflow flag and set the sign and zero flags from the result.
- R8: Opcode 0xF7 with specifier bits 5:3 equal to 2 returns the bitwise inverse of the memory operand with target code 2'b10 and leaves all three flags unchanged.
- R9: Any other opcode, including 0xF7 with specifier bits 5:3 other than 2, raises the illegal output, returns target code 2'b00 and leaves the flags unchanged.
- R10: After reset, the valid output, the illegal output, all flags, the result and the target code are zero.
- R11: The valid output is the request strobe delayed by exactly one clock. When no request is made, the result, target, index and illegal outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| opcode | input | 8 | Operation byte |
| spec | input | 8 | Operand-specifier byte; bits 5:3 give the register index or the sub-operation |
| reg_val | input | DATA_W | Register operand value |
| mem_val | input | DATA_W | Memory operand value |
| out_valid | output | 1 | Result valid, one clock after the request |
| result | output | DATA_W | Operation result (the difference for compares) |
| wb_tgt | output | 2 | Write-back target: 00 none, 01 register, 10 memory |
| wb_reg | output | 3 | Destination register index for target 01 |
| illegal | output | 1 | Opcode not decoded |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_o | output | 1 | Overflow flag |

## Verification
The bench builds the block with its default 32-bit data width. At this width the sign boundaries 0x7FFFFFFF/0x80000000 and the all-ones wraparound can be reached directly, so the overflow rules for add and for subtract/compare are exercised at their edges. Each direction pair is driven with asymmetric operands, which makes a swapped operand order visible in the result. Flag-preservation cases first put the flags into a known non-zero state and then issue a NOT or an undecoded opcode.

// File: rtl/alu2op_pkg.sv
package alu2op_pkg;
  typedef enum logic [2:0] {
    OPK_ADD, OPK_SUB, OPK_AND, OPK_OR, OPK_XOR, OPK_CMP, OPK_NOT, OPK_BAD
  } opk_e;

  typedef enum logic [1:0] {
    WB_NONE = 2'b00,
    WB_REG  = 2'b01,
    WB_MEM  = 2'b10
  } wb_e;
endpackage

// File: rtl/alu2op_decode.sv
module alu2op_decode
  import alu2op_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic [7:0] spec,
  output opk_e       kind,
  output logic       to_reg,
  output wb_e        target
);
  always_comb begin
    kind = OPK_BAD;
    unique case (opcode)
      8'h01, 8'h03: kind = OPK_ADD;
      8'h29, 8'h2B: kind = OPK_SUB;
      8'h21, 8'h23: kind = OPK_AND;
      8'h09, 8'h0B: kind = OPK_OR;
      8'h31, 8'h33: kind = OPK_XOR;
      8'h39, 8'h3B: kind = OPK_CMP;
      8'hF7:        kind = (spec[5:3] == 3'd2) ? OPK_NOT : OPK_BAD;
      default:      kind = OPK_BAD;
    endcase
  end

  // bit 1 of the two-operand opcodes selects memory-into-register
  assign to_reg = opcode[1] && (kind != OPK_NOT);

  always_comb begin
    if (kind == OPK_BAD || kind == OPK_CMP) target = WB_NONE;
    else if (to_reg)                        target = WB_REG;
    else                                    target = WB_MEM;
  end
endmodule

// File: rtl/alu2op_exec.sv
module alu2op_exec
  import alu2op_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  opk_e              kind,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic [DATA_W-1:0] res,
  output logic              s_n,
  output logic              z_n,
  output logic              o_n,
  output logic              upd
);
  localparam int WIDE_W = DATA_W + 1;

  logic [WIDE_W-1:0] a_wide, b_wide, sum_wide, dif_wide;

  assign a_wide   = {op_a[DATA_W-1], op_a};
  assign b_wide   = {op_b[DATA_W-1], op_b};
  assign sum_wide = a_wide + b_wide;
  assign dif_wide = a_wide - b_wide;

  always_comb begin
    res = '0;
    o_n = 1'b0;
    upd = 1'b1;
    unique case (kind)
      OPK_ADD: begin
        res = sum_wide[DATA_W-1:0];
        o_n = sum_wide[WIDE_W-1] ^ sum_wide[DATA_W-1];
      end
      OPK_SUB, OPK_CMP: begin
        res = dif_wide[DATA_W-1:0];
        o_n = dif_wide[WIDE_W-1] ^ dif_wide[DATA_W-1];
      end
      OPK_AND: res = op_a & op_b;
      OPK_OR:  res = op_a | op_b;
      OPK_XOR: res = op_a ^ op_b;
      OPK_NOT: begin
        res = ~op_a;
        upd = 1'b0;
      end
      default: upd = 1'b0;
    endcase
  end

  assign s_n = res[DATA_W-1];
  assign z_n = (res == '0);
endmodule

// File: rtl/alu2op_core.sv
module alu2op_core
  import alu2op_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        opcode,
  input  logic [7:0]        spec,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [DATA_W-1:0] mem_val,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [1:0]        wb_tgt,
  output logic [2:0]        wb_reg,
  output logic              illegal,
  output logic              flag_s,
  output logic              flag_z,
  output logic              flag_o
);
  opk_e              kind;
  logic              to_reg;
  wb_e               target;
  logic [DATA_W-1:0] op_a, op_b, res;
  logic              s_n, z_n, o_n, upd;

  alu2op_decode u_dec (
    .opcode (opcode),
    .spec   (spec),
    .kind   (kind),
    .to_reg (to_reg),
    .target (target)
  );

  // operand A is the destination side of the opcode's direction
  assign op_a = to_reg ? reg_val : mem_val;
  assign op_b = to_reg ? mem_val : reg_val;

  alu2op_exec #(.DATA_W(DATA_W)) u_exe (
    .kind (kind),
    .op_a (op_a),
    .op_b (op_b),
    .res  (res),
    .s_n  (s_n),
    .z_n  (z_n),
    .o_n  (o_n),
    .upd  (upd)
  );

  logic              vld_q, vld_d;
  logic [DATA_W-1:0] res_q, res_d;
  logic [1:0]        tgt_q, tgt_d;
  logic [2:0]        idx_q, idx_d;
  logic              ill_q, ill_d;
  logic [2:0]        flg_q, flg_d;
  logic              out_en, flg_en;

  assign out_en = in_valid;
  assign flg_en = in_valid && upd;

  always_comb begin
    vld_d = in_valid;
    res_d = res;
    tgt_d = target;
    idx_d = (target == WB_REG) ? spec[5:3] : 3'd0;
    ill_d = (kind == OPK_BAD);
    flg_d = {s_n, z_n, o_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      tgt_q <= WB_NONE;
      idx_q <= 3'd0;
      ill_q <= 1'b0;
      flg_q <= 3'b000;
    end else begin
      vld_q <= vld_d;
      if (out_en) begin
        res_q <= res_d;
        tgt_q <= tgt_d;
        idx_q <= idx_d;
        ill_q <= ill_d;
      end
      if (flg_en) flg_q <= flg_d;
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;
  assign wb_tgt    = tgt_q;
  assign wb_reg    = idx_q;
  assign illegal   = ill_q;
  assign flag_s    = flg_q[2];
  assign flag_z    = flg_q[1];
  assign flag_o    = flg_q[0];
endmodule

// File: rtl/alu2op_chk.sv
module alu2op_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [7:0]        opcode,
  input logic [7:0]        spec,
  input logic [DATA_W-1:0] mem_val,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic [1:0]        wb_tgt,
  input logic [2:0]        wb_reg,
  input logic              illegal,
  input logic              flag_s,
  input logic              flag_z,
  input logic              flag_o
);
  // R11
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R9
  illegal_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && illegal) |-> ($stable({flag_s, flag_z, flag_o}) && wb_tgt == 2'b00));

  // R4
  cmp_nowb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (opcode == 8'h39 || opcode == 8'h3B)) |=> (wb_tgt == 2'b00 && !illegal));

  // R7
  logic_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (opcode == 8'h21 || opcode == 8'h23 || opcode == 8'h09 ||
                  opcode == 8'h0B || opcode == 8'h31 || opcode == 8'h33)) |=> !flag_o);

  // R2
  reg_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (opcode == 8'h03 || opcode == 8'h2B || opcode == 8'h23 ||
                  opcode == 8'h0B || opcode == 8'h33)) |=> (wb_tgt == 2'b01 && wb_reg == $past(spec[5:3])));

  // R8
  invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 8'hF7 && spec[5:3] == 3'd2) |=>
      (result == ~$past(mem_val) && $stable({flag_s, flag_z, flag_o})));
endmodule

bind alu2op_core alu2op_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode), .spec(spec),
  .mem_val(mem_val), .out_valid(out_valid), .result(result), .wb_tgt(wb_tgt),
  .wb_reg(wb_reg), .illegal(illegal), .flag_s(flag_s), .flag_z(flag_z), .flag_o(flag_o)
);

// File: tb/alu2op_core_tb.sv
module alu2op_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic          clk, rst_n, in_valid;
  logic [7:0]    opcode, spec;
  logic [DW-1:0] reg_val, mem_val, result;
  logic          out_valid, illegal, flag_s, flag_z, flag_o;
  logic [1:0]    wb_tgt;
  logic [2:0]    wb_reg;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  alu2op_core #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode), .spec(spec),
    .reg_val(reg_val), .mem_val(mem_val), .out_valid(out_valid), .result(result),
    .wb_tgt(wb_tgt), .wb_reg(wb_reg), .illegal(illegal),
    .flag_s(flag_s), .flag_z(flag_z), .flag_o(flag_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at falling edge, capture at rising edge, sample at next falling edge
  task automatic issue(logic [7:0] op, logic [7:0] sp, logic [DW-1:0] rv, logic [DW-1:0] mv);
    opcode = op; spec = sp; reg_val = rv; mem_val = mv; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic chk_out(string req, logic [DW-1:0] res, logic [1:0] tgt, logic [2:0] idx,
                         logic ill, logic [2:0] flg);
    chk(req, {63'd0, out_valid}, 64'd1);
    chk(req, {32'd0, result}, {32'd0, res});
    chk(req, {62'd0, wb_tgt}, {62'd0, tgt});
    chk(req, {61'd0, wb_reg}, {61'd0, idx});
    chk(req, {63'd0, illegal}, {63'd0, ill});
    chk(req, {61'd0, flag_s, flag_z, flag_o}, {61'd0, flg});
  endtask

  task automatic t_reset;
    chk("R10", {63'd0, out_valid}, 64'd0);
    chk("R10", {32'd0, result}, 64'd0);
    chk("R10", {62'd0, wb_tgt}, 64'd0);
    chk("R10", {63'd0, illegal}, 64'd0);
    chk("R10", {61'd0, flag_s, flag_z, flag_o}, 64'd0);
  endtask

  task automatic t_mem_dest;
    issue(8'h01, 8'h18, 32'h10, 32'h1);          chk_out("R1 add", 32'h11, 2'b10, 3'd0, 1'b0, 3'b000);
    issue(8'h21, 8'h18, 32'hFF, 32'h0A0B0C0D);   chk_out("R1 and", 32'h0D, 2'b10, 3'd0, 1'b0, 3'b000);
    issue(8'h09, 8'h18, 32'hA0B0C0D0, 32'h0A0B0C0D); chk_out("R1 or", 32'hAABBCCDD, 2'b10, 3'd0, 1'b0, 3'b100);
    issue(8'h31, 8'h18, 32'hA0B0C0D0, 32'hAABB0C0D); chk_out("R1 xor", 32'h0A0BCCDD, 2'b10, 3'd0, 1'b0, 3'b000);
  endtask

  task automatic t_reg_dest;
    issue(8'h03, 8'h18, 32'h10, 32'h1);          chk_out("R2 add", 32'h11, 2'b01, 3'd3, 1'b0, 3'b000);
    issue(8'h33, 8'h28, 32'hA0B0C0D0, 32'hA0B0C0D0); chk_out("R2 xor", 32'h0, 2'b01, 3'd5, 1'b0, 3'b010);
    issue(8'h0B, 8'h38, 32'h0, 32'h1);           chk_out("R2 or", 32'h1, 2'b01, 3'd7, 1'b0, 3'b000);
  endtask

  task automatic t_sub_order;
    issue(8'h29, 8'h18, 32'h1, 32'hA);           chk_out("R3 29", 32'h9, 2'b10, 3'd0, 1'b0, 3'b000);
    issue(8'h2B, 8'h18, 32'hA, 32'h1);           chk_out("R3 2B", 32'h9, 2'b01, 3'd3, 1'b0, 3'b000);
    issue(8'h2B, 8'h08, 32'h1, 32'hA);           chk_out("R3 2B neg", 32'hFFFFFFF7, 2'b01, 3'd1, 1'b0, 3'b100);
  endtask

  task automatic t_compare;
    issue(8'h39, 8'h18, 32'h0A0B0C07, 32'h0A0B0C0D); chk_out("R4 39 gt", 32'h6, 2'b00, 3'd0, 1'b0, 3'b000);
    issue(8'h39, 8'h18, 32'h0A0B0C0D, 32'h0A0B0C07); chk_out("R4 39 lt", 32'hFFFFFFFA, 2'b00, 3'd0, 1'b0, 3'b100);
    issue(8'h3B, 8'h18, 32'h0A0B0C07, 32'h0A0B0C0D); chk_out("R4 3B lt", 32'hFFFFFFFA, 2'b00, 3'd0, 1'b0, 3'b100);
    issue(8'h3B, 8'h18, 32'h0A0B0C0D, 32'h0A0B0C0D); chk_out("R4 3B eq", 32'h0, 2'b00, 3'd0, 1'b0, 3'b010);
  endtask

  task automatic t_sub_ovf;
    issue(8'h2B, 8'h00, 32'h80000000, 32'h1);    chk_out("R5 min-1", 32'h7FFFFFFF, 2'b01, 3'd0, 1'b0, 3'b001);
    issue(8'h39, 8'h00, 32'hFFFFFFFF, 32'h7FFFFFFF); chk_out("R5 cmp", 32'h80000000, 2'b00, 3'd0, 1'b0, 3'b101);
    issue(8'h29, 8'h00, 32'h7FFFFFFF, 32'hFFFFFFFF); chk_out("R5 noovf", 32'h80000000, 2'b10, 3'd0, 1'b0, 3'b100);
  endtask

  task automatic t_add_wrap;
    issue(8'h01, 8'h00, 32'h1, 32'h7FFFFFFF);    chk_out("R6 ovf", 32'h80000000, 2'b10, 3'd0, 1'b0, 3'b101);
    issue(8'h03, 8'h00, 32'hFFFFFFFF, 32'h1);    chk_out("R6 wrap", 32'h0, 2'b01, 3'd0, 1'b0, 3'b010);
    issue(8'h01, 8'h00, 32'h80000000, 32'h80000000); chk_out("R6 negovf", 32'h0, 2'b10, 3'd0, 1'b0, 3'b011);
  endtask

  task automatic t_logic_flags;
    issue(8'h01, 8'h00, 32'h1, 32'h7FFFFFFF);    // sets OF
    issue(8'h23, 8'h00, 32'hF0000000, 32'h80000001); chk_out("R7 and", 32'h80000000, 2'b01, 3'd0, 1'b0, 3'b100);
    issue(8'h01, 8'h00, 32'h1, 32'h7FFFFFFF);
    issue(8'h21, 8'h00, 32'h0F, 32'hF0);         chk_out("R7 zero", 32'h0, 2'b10, 3'd0, 1'b0, 3'b010);
  endtask

  task automatic t_invert;
    issue(8'h01, 8'h00, 32'h1, 32'h7FFFFFFF);    // flags 101
    issue(8'hF7, 8'h13, 32'h12345678, 32'h0F0F00FF); chk_out("R8 not", 32'hF0F0FF00, 2'b10, 3'd0, 1'b0, 3'b101);
  endtask

  task automatic t_illegal;
    issue(8'h3B, 8'h00, 32'h5, 32'h5);           // flags 010
    issue(8'h05, 8'h18, 32'h5, 32'h6);
    chk("R9 bad", {63'd0, illegal}, 64'd1);
    chk("R9 bad", {62'd0, wb_tgt}, 64'd0);
    chk("R9 bad", {61'd0, flag_s, flag_z, flag_o}, 64'b010);
    issue(8'hF7, 8'h18, 32'h5, 32'h6);
    chk("R9 F7/3", {63'd0, illegal}, 64'd1);
    chk("R9 F7/3", {62'd0, wb_tgt}, 64'd0);
    chk("R9 F7/3", {61'd0, flag_s, flag_z, flag_o}, 64'b010);
    issue(8'h03, 8'h10, 32'h2, 32'h3);
    chk("R9 clear", {63'd0, illegal}, 64'd0);
  endtask

  task automatic t_hold;
    issue(8'h09, 8'h00, 32'h00000100, 32'h00000011);
    chk("R11 valid", {63'd0, out_valid}, 64'd1);
    opcode = 8'h29; spec = 8'h38; reg_val = 32'h1; mem_val = 32'h0;
    @(negedge clk);
    chk("R11 idle", {63'd0, out_valid}, 64'd0);
    chk("R11 hold", {32'd0, result}, 64'h111);
    chk("R11 hold", {62'd0, wb_tgt}, 64'b10);
    chk("R11 hold", {61'd0, flag_s, flag_z, flag_o}, 64'b000);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; opcode = '0; spec = '0; reg_val = '0; mem_val = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mem_dest();
    t_reg_dest();
    t_sub_order();
    t_compare();
    t_sub_ovf();
    t_add_wrap();
    t_logic_flags();
    t_invert();
    t_illegal();
    t_hold();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule